// File: doc/BRIEF.md
# Serial Memory Status Register Controller

This block is the slave-side command logic that owns the status register of a serial memory on an SPI bus. It watches chip select, the serial clock, serial data in and a write-protect pin, and drives serial data out. It decodes four single-byte instructions: set the write-enable latch, clear the write-enable latch, read the status register, and write the status register. The status register holds a status-register-write-disable bit, two block-protect bits, the write-enable latch and a write-in-progress flag.

A status write does not take effect at once. When the frame is accepted, a self-timed commit runs for a parameter number of system clocks. During that time the write-in-progress flag reads 1 and the new protection bits stay hidden. At the end of the commit the new values appear and the write-enable latch clears. The bus pins are brought into the system clock domain by two-stage synchronizers, and the serial clock is oversampled. The serial clock must therefore be slower than a few system clocks per phase.

Top module: `sreg_ctrl`

## Requirements
- R1: A status-write frame (opcode 0x01) received while the write-enable latch (status bit 1) is 0 changes no status bit and starts no commit.
- R2: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it, but only when chip select rises after exactly 8 sampled clock rising edges. With 7 or 9 edges the latch is unchanged.
- R3: A status write is accepted only when chip select rises after exactly 16 sampled rising edges (opcode plus one data byte). With 15 or 17 edges it is discarded, the latch stays set and no commit starts.
- R4: An accepted status write holds write-in-progress (status bit 0) at 1 for exactly WR_CYCLES system clocks, then returns it to 0.
- R5: The write-enable latch reads 0 once the commit has finished.
- R6: Only bits 7 (write disable), 3 and 2 (block protect) take data-byte values. Bits 6, 5 and 4 always read 0, and bits 1 and 0 always show the latch and the busy flag.
- R7: During the commit, bits 7, 3 and 2 keep their old values. The new values appear only when write-in-progress falls.
- R8: Opcode 0x05 shifts the status byte out MSB first. Data changes on falling clock edges, starting at the falling edge after the 8th rising edge. The byte repeats with a fresh value for as long as clocks continue, so the busy flag can be polled during a commit.
- R9: While bit 7 is 1 and the write-protect pin is low, a status write is refused and the latch keeps its value. With the pin high, the write proceeds.
- R10: While a commit is busy, the write-enable, write-disable and status-write opcodes have no effect.
- R11: After reset the status reads 0x00. The output enable is 0 whenever chip select is high or no status read is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the bus master |
| mosi | input | 1 | Serial data in, sampled on sclk rising edges |
| wp_n | input | 1 | Write-protect pin, active low |
| miso | output | 1 | Serial data out, valid while miso_oe is 1 |
| miso_oe | output | 1 | Output enable for miso (0 means high impedance) |

## Verification
The main function, a status write, is tried with a sweep of 64 data bytes. The sweep covers every combination of the writable bits together with set values in the read-only positions, which separates correct masking from leakage of stray data bits. Frames cut one bit short and frames with one bit too many are sent both for the latch opcodes and for the status write. These tell the exact-boundary rule apart from a looser "at least" rule. Reads issued during a commit, and a write-disable sent during a commit, show whether the busy flag is live and whether the old protection values stay hidden. The protect pin is tried low and high while bit 7 is set.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    localparam int          CNT_W   = 5;
    localparam logic [7:0]  OP_WEN  = 8'h06;
    localparam logic [7:0]  OP_WDIS = 8'h04;
    localparam logic [7:0]  OP_RDST = 8'h05;
    localparam logic [7:0]  OP_WRST = 8'h01;

    localparam logic [CNT_W-1:0] LEN_CMD  = CNT_W'(8);
    localparam logic [CNT_W-1:0] LEN_WRST = CNT_W'(16);

    // Bit positions in the status byte
    localparam int B_WDIS = 7;
    localparam int B_BP1  = 3;
    localparam int B_BP0  = 2;
    localparam int B_WEL  = 1;
    localparam int B_BUSY = 0;

    typedef struct packed {
        logic             cs_prev;
        logic             sclk_prev;
        logic [CNT_W-1:0] cnt;
        logic [2:0]       ph;
        logic [7:0]       sh;
        logic [7:0]       op;
        logic [7:0]       dat;
        logic             rd_act;
        logic [7:0]       out;
        logic             so;
    } frame_st_t;

endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
    parameter int         W       = 4,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/sreg_frame.sv
module sreg_frame
    import sreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n_s,
    input  logic             sclk_s,
    input  logic             mosi_s,
    input  logic [7:0]       status,
    output logic             cs_rise,
    output logic [CNT_W-1:0] nbits,
    output logic [7:0]       opcode,
    output logic [7:0]       data,
    output logic             so,
    output logic             so_oe
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    frame_st_t st_d, st_q;
    logic      sclk_rise, sclk_fall, cs_fall;
    logic [7:0] shifted;

    always_comb begin
        sclk_rise = sclk_s && !st_q.sclk_prev;
        sclk_fall = !sclk_s && st_q.sclk_prev;
        cs_fall   = !cs_n_s && st_q.cs_prev;
        cs_rise   = cs_n_s && !st_q.cs_prev;
        shifted   = {st_q.sh[6:0], mosi_s};

        st_d           = st_q;
        st_d.cs_prev   = cs_n_s;
        st_d.sclk_prev = sclk_s;

        if (cs_fall) begin
            st_d.cnt    = '0;
            st_d.ph     = '0;
            st_d.op     = '0;
            st_d.rd_act = 1'b0;
        end else if (cs_rise) begin
            st_d.rd_act = 1'b0;
        end else if (!cs_n_s) begin
            if (sclk_rise) begin
                st_d.sh = shifted;
                st_d.ph = st_q.ph + 3'd1;
                if (st_q.cnt != CNT_MAX) begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
                if (st_q.cnt == LEN_CMD - CNT_W'(1)) begin
                    st_d.op     = shifted;
                    st_d.rd_act = (shifted == OP_RDST);
                end
                if (st_q.cnt == LEN_WRST - CNT_W'(1)) begin
                    st_d.dat = shifted;
                end
            end else if (sclk_fall && st_q.rd_act) begin
                if (st_q.ph == 3'd0) begin
                    st_d.so  = status[7];
                    st_d.out = {status[6:0], 1'b0};
                end else begin
                    st_d.so  = st_q.out[7];
                    st_d.out = {st_q.out[6:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.cs_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign nbits  = st_q.cnt;
    assign opcode = st_q.op;
    assign data   = st_q.dat;
    assign so_oe  = !cs_n_s && st_q.rd_act;
    assign so     = so_oe ? st_q.so : 1'b0;

endmodule

// File: rtl/sreg_core.sv
module sreg_core
    import sreg_pkg::*;
#(
    parameter int WR_CYCLES = 5000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_rise,
    input  logic [CNT_W-1:0] nbits,
    input  logic [7:0]       opcode,
    input  logic [7:0]       data,
    input  logic             wp_n_s,
    output logic [7:0]       status
);

    localparam int TW = $clog2(WR_CYCLES + 1);
    localparam logic [TW-1:0] T_LOAD = TW'(WR_CYCLES);

    typedef struct packed {
        logic          wel;
        logic          busy;
        logic          wdis;
        logic [1:0]    bp;
        logic          pend_wdis;
        logic [1:0]    pend_bp;
        logic [TW-1:0] tmr;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     locked, is_cmd, is_wr;

    always_comb begin
        locked = st_q.wdis && !wp_n_s;
        is_cmd = cs_rise && (nbits == LEN_CMD);
        is_wr  = cs_rise && (nbits == LEN_WRST) && (opcode == OP_WRST);

        st_d = st_q;
        if (st_q.busy) begin
            if (st_q.tmr == TW'(1)) begin
                st_d.busy = 1'b0;
                st_d.wel  = 1'b0;
                st_d.wdis = st_q.pend_wdis;
                st_d.bp   = st_q.pend_bp;
            end
            st_d.tmr = st_q.tmr - TW'(1);
        end else if (is_cmd && opcode == OP_WEN) begin
            st_d.wel = 1'b1;
        end else if (is_cmd && opcode == OP_WDIS) begin
            st_d.wel = 1'b0;
        end else if (is_wr && st_q.wel && !locked) begin
            st_d.pend_wdis = data[B_WDIS];
            st_d.pend_bp   = {data[B_BP1], data[B_BP0]};
            st_d.busy      = 1'b1;
            st_d.tmr       = T_LOAD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        status         = 8'h00;
        status[B_WDIS] = st_q.wdis;
        status[B_BP1]  = st_q.bp[1];
        status[B_BP0]  = st_q.bp[0];
        status[B_WEL]  = st_q.wel;
        status[B_BUSY] = st_q.busy;
    end

endmodule

// File: rtl/sreg_ctrl.sv
module sreg_ctrl
    import sreg_pkg::*;
#(
    parameter int WR_CYCLES   = 5000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic mosi,
    input  logic wp_n,
    output logic miso,
    output logic miso_oe
);

    logic [3:0]       pins_s;
    logic             cs_rise_w;
    logic [CNT_W-1:0] nbits_w;
    logic [7:0]       opcode_w, data_w, status_w;
    logic             wp_s;

    sreg_sync #(
        .W       (4),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b1001)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({cs_n, sclk, mosi, wp_n}),
        .dout  (pins_s)
    );

    assign wp_s = pins_s[0];

    sreg_frame u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n_s  (pins_s[3]),
        .sclk_s  (pins_s[2]),
        .mosi_s  (pins_s[1]),
        .status  (status_w),
        .cs_rise (cs_rise_w),
        .nbits   (nbits_w),
        .opcode  (opcode_w),
        .data    (data_w),
        .so      (miso),
        .so_oe   (miso_oe)
    );

    sreg_core #(
        .WR_CYCLES (WR_CYCLES)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_rise (cs_rise_w),
        .nbits   (nbits_w),
        .opcode  (opcode_w),
        .data    (data_w),
        .wp_n_s  (wp_s),
        .status  (status_w)
    );

endmodule

// File: rtl/sreg_ctrl_chk.sv
module sreg_ctrl_chk #(
    parameter int WR_CYCLES = 5000
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] status,
    input logic       wp_s,
    input logic       cs_rise
);

    int busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= 0;
        end else if (status[0]) begin
            busy_cnt <= busy_cnt + 1;
        end else begin
            busy_cnt <= 0;
        end
    end

    p_needs_latch_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> ($past(status[1]) && $past(cs_rise)));

    p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[0]) |-> (busy_cnt == WR_CYCLES));

    p_latch_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[0]) |-> !status[1]);

    p_late_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status[7:2]) |-> $fell(status[0]));

    p_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> !($past(status[7]) && !$past(wp_s)));

    p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[1]) |-> !$past(status[0]));

endmodule

bind sreg_ctrl sreg_ctrl_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .status  (status_w),
    .wp_s    (wp_s),
    .cs_rise (cs_rise_w)
);

// File: tb/sim_sreg_ctrl.sv
module sim_sreg_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int WRC        = 400;
    localparam int H          = 4;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0, wp_n = 1'b1;
    logic miso, miso_oe;

    int total = 0;
    int bad   = 0;
    logic [15:0] rd16;
    logic        oe_seen;

    always #(CLK_PERIOD/2) clk = ~clk;

    sreg_ctrl #(.WR_CYCLES(WRC)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
        .mosi(mosi), .wp_n(wp_n), .miso(miso), .miso_oe(miso_oe)
    );

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic frame(input logic [23:0] w, input int n);
        rd16    = '0;
        oe_seen = 1'b0;
        cs_n = 1'b0;
        waitc(H);
        for (int b = 0; b < n; b++) begin
            mosi = w[n-1-b];
            waitc(H);
            if (miso_oe) oe_seen = 1'b1;
            if (b >= 8 && b < 24) rd16 = {rd16[14:0], miso};
            sclk = 1'b1;
            waitc(H);
            sclk = 1'b0;
        end
        waitc(H);
        cs_n = 1'b1;
        waitc(2*H);
    endtask

    task automatic rdsr(output logic [15:0] v);
        frame(24'h050000, 24);
        v = rd16;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] exp);
        logic [15:0] v;
        rdsr(v);
        chk(req, v[15:8], exp);
    endtask

    task automatic wren();
        frame(24'h000006, 8);
    endtask

    task automatic wrst(input logic [7:0] d);
        frame({8'h00, 8'h01, d}, 16);
    endtask

    initial begin : main
        logic [15:0] v;
        logic [7:0]  d;
        waitc(5);
        rst_n = 1'b1;
        waitc(5);

        // R11: reset state and idle output enable
        chk("R11 oe idle", {7'd0, miso_oe}, 8'h00);
        rd_chk("R11 reset status", 8'h00);
        chk("R11 oe after read", {7'd0, miso_oe}, 8'h00);

        // R1: status write without latch
        wrst(8'h8C);
        waitc(WRC + 20);
        rd_chk("R1 no latch", 8'h00);

        // R2: latch opcodes and the exact 8-bit boundary
        frame(24'h000003, 7);
        rd_chk("R2 wren 7 bits", 8'h00);
        frame(24'h00000C, 9);
        rd_chk("R2 wren 9 bits", 8'h00);
        wren();
        chk("R11 oe during wren", {7'd0, oe_seen}, 8'h00);
        rd_chk("R2 wren", 8'h02);
        frame(24'h000008, 9);
        rd_chk("R2 wrdi 9 bits", 8'h02);
        frame(24'h000004, 8);
        rd_chk("R2 wrdi", 8'h00);

        // R3: status write boundary
        wren();
        frame({8'h00, 8'h01, 8'h8C} >> 1, 15);
        waitc(20);
        rd_chk("R3 15 bits", 8'h02);
        frame({7'h00, 8'h01, 8'h8C, 1'b0}, 17);
        waitc(20);
        rd_chk("R3 17 bits", 8'h02);

        // R4 R7 R8 R10: commit in progress
        wrst(8'h0C);
        rdsr(v);
        chk("R8 poll first byte", v[15:8], 8'h03);
        chk("R8 poll repeat byte", v[7:0], 8'h03);
        frame(24'h000004, 8);
        rd_chk("R10 wrdi ignored while busy", 8'h03);
        waitc(WRC);
        rd_chk("R4 R5 R7 after commit", 8'h0C);

        // R6: sweep of data bytes
        for (int i = 0; i < 64; i++) begin
            d = 8'((i << 2) | (i >> 4) | ((i & 1) << 6));
            if (i == 63) d = 8'hFF;
            if (i == 62) d = 8'h73;
            wren();
            wrst(d);
            waitc(WRC + 20);
            rd_chk("R6 sweep", d & 8'h8C);
        end
        wren();
        wrst(8'h80);
        waitc(WRC + 20);
        rd_chk("R6 set wdis", 8'h80);

        // R9: write protect
        wp_n = 1'b0;
        wren();
        wrst(8'h00);
        waitc(WRC + 20);
        rd_chk("R9 locked", 8'h82);
        wp_n = 1'b1;
        waitc(10);
        wrst(8'h00);
        waitc(WRC + 20);
        rd_chk("R9 unlocked", 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule